// File: doc/BRIEF.md
# Variable-Page-Size Unified Translation Buffer

This block holds a set of address translations and searches all of them at once to turn a 32-bit virtual address into a physical one. Every entry has its own page size (1 KB, 4 KB, 64 KB or 1 MB), so the bits that take part in the comparison and the bits copied from the virtual address vary per entry. Entries also carry an address-space identifier, a shared flag, a protection code and a dirty flag. The protection code and the dirty flag are returned with a hit so that a later stage can check them.

Software-visible state is loaded through a single write port. That port takes an entry index plus a tag word and a data word. A lookup request carries the virtual address, the current address-space identifier, the privilege mode and the single-virtual-space bit. The registered result appears one cycle later and is a hit, a miss or a multi-hit. A free-running replacement pointer advances on ordinary lookups and wraps at a programmable boundary. A flush pulse invalidates the whole table.

Top module: `vpage_tlb`

## Requirements
- R1: A load writes entry `ld_idx` from two words. Tag word: bits 31:10 are the virtual page number and bits 7:0 are the address-space identifier. Data word: bits 31:10 are the physical page number, bit 9 is valid, bit 8 is shared, bits 7:6 are the size code, bits 5:4 are protection and bit 3 is dirty. All other bits are ignored.
- R2: Size code 0, 1, 2 or 3 selects a 1 KB, 4 KB, 64 KB or 1 MB page. The page mask clears the low 10, 12, 16 or 20 address bits.
- R3: An entry matches only when its valid bit is 1 and the virtual address equals the stored page number (shifted up by 10) in every bit kept by that entry's mask.
- R4: The identifier compare is also required, except when the entry is shared or when the lookup has both `lk_priv` and `lk_sv` set. In either of those cases the page compare alone decides.
- R5: `res_valid` is high for exactly the cycle after a cycle with `lk_req` high. When exactly one entry matches, `res_hit` is set. `res_pa` is then the entry's physical page (shifted up by 10) under the mask, ORed with the virtual address bits outside the mask. `res_idx`, `res_prot` and `res_dirty` come from that entry.
- R6: With no match `res_miss` is set. With two or more matches `res_multi` is set. In both cases `res_pa`, `res_idx`, `res_prot` and `res_dirty` are zero.
- R7: Each lookup with `lk_internal` low advances `urc` by one, modulo 64. If the advanced value equals `urb`, `urc` becomes 0 instead. Internal lookups and idle cycles leave `urc` unchanged.
- R8: A `flush` pulse clears the valid bit of every entry. A load in the same cycle still writes its entry with the valid bit it carries.
- R9: A lookup in the same cycle as a load sees the contents the entry had before the load.
- R10: After reset all entries are invalid, `urc` is 0, and `res_valid` and the three status outputs are 0.
- R11: At most one of `res_hit`, `res_miss` and `res_multi` is high. Exactly one is high when `res_valid` is high, and none is high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| ld_en | input | 1 | Write one entry this cycle |
| ld_idx | input | 6 | Entry index to write |
| ld_tag | input | 32 | Page number and identifier word |
| ld_data | input | 32 | Physical page and attribute word |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_priv | input | 1 | Privileged access |
| lk_sv | input | 1 | Single-virtual-space mode |
| lk_internal | input | 1 | Lookup does not advance the replacement pointer |
| urb | input | 6 | Replacement pointer wrap boundary |
| res_valid | output | 1 | Result valid this cycle |
| res_hit | output | 1 | Exactly one match |
| res_miss | output | 1 | No match |
| res_multi | output | 1 | Several matches |
| res_pa | output | 32 | Translated physical address |
| res_idx | output | 6 | Index of the matching entry |
| res_prot | output | 2 | Protection code of the match |
| res_dirty | output | 1 | Dirty flag of the match |
| urc | output | 6 | Replacement pointer |

## Verification
A corrupted entry cannot be seen until some lookup touches its page. It then shows up one cycle after that lookup as a wrong address, a wrong index, or a miss or multi-hit in place of a hit. For this reason the stimulus probes every page size at its edges, covers every case of the identifier rule, and adds a long random mix of overlapping pages. A wrong replacement pointer shows on `urc` on the cycle right after the lookup that moved it. The reference model is compared on every clock, so the first divergent cycle is reported.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  localparam int VA_W   = 32;
  localparam int PG_SH  = 10;
  localparam int VPN_W  = VA_W - PG_SH;
  localparam int ASID_W = 8;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  ppn;
    logic              v;
    logic              sh;
    logic [1:0]        sz;
    logic [1:0]        pr;
    logic              d;
  } tlb_entry_t;

  // size code -> mask with the in-page offset bits cleared
  function automatic logic [VA_W-1:0] page_mask(input logic [1:0] code);
    logic [VA_W-1:0] ones;
    ones = '1;
    case (code)
      2'd0:    page_mask = ones << 10;
      2'd1:    page_mask = ones << 12;
      2'd2:    page_mask = ones << 16;
      default: page_mask = ones << 20;
    endcase
  endfunction
endpackage

// File: rtl/vtlb_store.sv
module vtlb_store
  import vtlb_pkg::*;
#(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 ld_en,
  input  logic [IW-1:0]        ld_idx,
  input  tlb_entry_t           ld_ent,
  output tlb_entry_t [N-1:0]   ents
);
  logic [N-1:0] vbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      ents <= '0;
    end else begin
      if (flush) begin
        for (int i = 0; i < N; i++) ents[i].v <= 1'b0;
      end
      if (ld_en) ents[ld_idx] <= ld_ent;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_v
    assign vbits[g] = ents[g].v;
  end

  // R8: a flush without a load leaves no valid entry
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (flush && !ld_en) |=> (vbits == '0));
  // R10: table empty straight after reset
  p_reset_empty_r10: assert property (@(posedge clk)
    rst |=> (vbits == '0));
endmodule

// File: rtl/vtlb_match.sv
module vtlb_match
  import vtlb_pkg::*;
#(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  tlb_entry_t [N-1:0]  ents,
  input  logic [VA_W-1:0]     va,
  input  logic [ASID_W-1:0]   asid,
  input  logic                priv,
  input  logic                sv,
  output logic [VA_W-1:0]     pa,
  output logic [IW-1:0]       idx,
  output logic [1:0]          prot,
  output logic                dirty,
  output logic                none,
  output logic                one,
  output logic                many
);
  localparam logic [PG_SH-1:0] PG_ZERO = '0;

  logic [N-1:0]    hits;
  logic [VA_W-1:0] xl [N];
  logic            asid_free;

  assign asid_free = priv && sv;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic [VA_W-1:0] msk;
    logic            page_eq;
    logic            id_ok;
    assign msk     = page_mask(ents[g].sz);
    assign page_eq = ((({ents[g].vpn, PG_ZERO}) ^ va) & msk) == '0;
    assign id_ok   = ents[g].sh || asid_free || (ents[g].asid == asid);
    assign hits[g] = ents[g].v && page_eq && id_ok;
    assign xl[g]   = ({ents[g].ppn, PG_ZERO} & msk) | (va & ~msk);
  end

  always_comb begin
    pa    = '0;
    idx   = '0;
    prot  = '0;
    dirty = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hits[i]) begin
        pa    = pa | xl[i];
        idx   = idx | IW'(i);
        prot  = prot | ents[i].pr;
        dirty = dirty | ents[i].d;
      end
    end
  end

  assign none = (hits == '0);
  assign many = (hits & (hits - N'(1))) != '0;
  assign one  = !none && !many;
endmodule

// File: rtl/vtlb_repl.sv
module vtlb_repl #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [IW-1:0] bound,
  output logic [IW-1:0] ptr
);
  logic [IW-1:0] nxt;
  assign nxt = ptr + IW'(1);

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (step) ptr <= (nxt == bound) ? '0 : nxt;
  end

  // R7: pointer only moves on a counted lookup
  p_urc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(ptr));
  // R7: a counted lookup either advances by one or wraps to zero
  p_urc_step_r7: assert property (@(posedge clk) disable iff (rst)
    step |=> ((ptr == '0) || (ptr == $past(ptr) + IW'(1))));
endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IW      = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              ld_en,
  input  logic [IW-1:0]     ld_idx,
  input  logic [VA_W-1:0]   ld_tag,
  input  logic [VA_W-1:0]   ld_data,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_priv,
  input  logic              lk_sv,
  input  logic              lk_internal,
  input  logic [IW-1:0]     urb,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_multi,
  output logic [VA_W-1:0]   res_pa,
  output logic [IW-1:0]     res_idx,
  output logic [1:0]        res_prot,
  output logic              res_dirty,
  output logic [IW-1:0]     urc
);
  tlb_entry_t               ld_ent;
  tlb_entry_t [ENTRIES-1:0] ents;
  logic [VA_W-1:0]          m_pa;
  logic [IW-1:0]            m_idx;
  logic [1:0]               m_prot;
  logic                     m_dirty, m_none, m_one, m_many;
  logic                     unused_bits;

  assign ld_ent.vpn  = ld_tag[VA_W-1:PG_SH];
  assign ld_ent.asid = ld_tag[ASID_W-1:0];
  assign ld_ent.ppn  = ld_data[VA_W-1:PG_SH];
  assign ld_ent.v    = ld_data[9];
  assign ld_ent.sh   = ld_data[8];
  assign ld_ent.sz   = ld_data[7:6];
  assign ld_ent.pr   = ld_data[5:4];
  assign ld_ent.d    = ld_data[3];
  assign unused_bits = ^{ld_tag[PG_SH-1:ASID_W], ld_data[2:0]};

  vtlb_store #(.N(ENTRIES), .IW(IW)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .ld_en(ld_en),
    .ld_idx(ld_idx), .ld_ent(ld_ent), .ents(ents)
  );

  vtlb_match #(.N(ENTRIES), .IW(IW)) u_match (
    .ents(ents), .va(lk_va), .asid(lk_asid), .priv(lk_priv), .sv(lk_sv),
    .pa(m_pa), .idx(m_idx), .prot(m_prot), .dirty(m_dirty),
    .none(m_none), .one(m_one), .many(m_many)
  );

  vtlb_repl #(.IW(IW)) u_repl (
    .clk(clk), .rst(rst), .step(lk_req && !lk_internal),
    .bound(urb), .ptr(urc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_multi <= 1'b0;
      res_pa    <= '0;
      res_idx   <= '0;
      res_prot  <= '0;
      res_dirty <= 1'b0;
    end else begin
      res_valid <= lk_req;
      res_hit   <= lk_req && m_one;
      res_miss  <= lk_req && m_none;
      res_multi <= lk_req && m_many;
      if (lk_req) begin
        res_pa    <= m_one ? m_pa    : '0;
        res_idx   <= m_one ? m_idx   : '0;
        res_prot  <= m_one ? m_prot  : '0;
        res_dirty <= m_one ? m_dirty : 1'b0;
      end
    end
  end

  // R5: result follows a request by one cycle
  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> res_valid);
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !res_valid);
  // R5: in-page offset passes straight through on a hit
  p_offset_r5: assert property (@(posedge clk) disable iff (rst)
    (lk_req && m_one) |=> (res_pa[PG_SH-1:0] == $past(lk_va[PG_SH-1:0])));
  // R6: nothing but zeros on a failed translation
  p_nohit_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_pa == '0 && res_idx == '0));
  // R11: status outputs are exclusive
  p_status_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $onehot({res_hit, res_miss, res_multi}));
  p_status_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !(res_hit || res_miss || res_multi));
endmodule

// File: tb/vpage_tlb_test.sv
module vpage_tlb_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 0, ld_en = 0, lk_req = 0, lk_priv = 0, lk_sv = 0, lk_internal = 0;
  logic [5:0]  ld_idx = 0, urb = 0;
  logic [31:0] ld_tag = 0, ld_data = 0, lk_va = 0;
  logic [7:0]  lk_asid = 0;
  logic        res_valid, res_hit, res_miss, res_multi, res_dirty;
  logic [31:0] res_pa;
  logic [5:0]  res_idx, urc;
  logic [1:0]  res_prot;

  always #10 clk = ~clk;

  vpage_tlb uut (
    .clk(clk), .rst(rst), .flush(flush), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_tag(ld_tag), .ld_data(ld_data), .lk_req(lk_req), .lk_va(lk_va),
    .lk_asid(lk_asid), .lk_priv(lk_priv), .lk_sv(lk_sv), .lk_internal(lk_internal),
    .urb(urb), .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_multi(res_multi), .res_pa(res_pa), .res_idx(res_idx),
    .res_prot(res_prot), .res_dirty(res_dirty), .urc(urc)
  );

  int checks = 0, errors = 0;
  string phase = "R10 reset";
  bit started = 0, done = 0;

  // behavioural reference
  logic [21:0] m_vpn [64];
  logic [21:0] m_ppn [64];
  logic [7:0]  m_asid [64];
  logic [1:0]  m_sz [64];
  logic [1:0]  m_pr [64];
  bit          m_v [64], m_sh [64], m_d [64];
  logic [5:0]  m_urc;
  bit          e_valid, e_hit, e_miss, e_multi, e_dirty;
  logic [31:0] e_pa;
  logic [5:0]  e_idx;
  logic [1:0]  e_prot;
  int          cnt, shv;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      for (int i = 0; i < 64; i++) begin
        m_v[i] = 0; m_sh[i] = 0; m_d[i] = 0;
        m_vpn[i] = 0; m_ppn[i] = 0; m_asid[i] = 0; m_sz[i] = 0; m_pr[i] = 0;
      end
      m_urc = 0; e_valid = 0; e_hit = 0; e_miss = 0; e_multi = 0;
      e_pa = 0; e_idx = 0; e_prot = 0; e_dirty = 0;
    end else begin
      e_valid = lk_req; e_hit = 0; e_miss = 0; e_multi = 0;
      if (lk_req) begin
        cnt = 0; e_pa = 0; e_idx = 0; e_prot = 0; e_dirty = 0;
        for (int i = 0; i < 64; i++) begin
          shv = (m_sz[i] == 2'd0) ? 10 : (m_sz[i] == 2'd1) ? 12 : (m_sz[i] == 2'd2) ? 16 : 20;
          if (m_v[i] && ((lk_va >> shv) == ({m_vpn[i], 10'd0} >> shv)) &&
              (m_sh[i] || (lk_priv && lk_sv) || (m_asid[i] == lk_asid))) begin
            cnt++;
            e_pa = (({m_ppn[i], 10'd0} >> shv) << shv) | (lk_va & ((32'd1 << shv) - 32'd1));
            e_idx = 6'(i); e_prot = m_pr[i]; e_dirty = m_d[i];
          end
        end
        e_hit = (cnt == 1); e_miss = (cnt == 0); e_multi = (cnt > 1);
        if (cnt != 1) begin e_pa = 0; e_idx = 0; e_prot = 0; e_dirty = 0; end
        if (!lk_internal) begin
          m_urc = 6'(m_urc + 6'd1);
          if (m_urc == urb) m_urc = 0;
        end
      end
      if (flush) for (int i = 0; i < 64; i++) m_v[i] = 0;
      if (ld_en) begin
        m_vpn[ld_idx] = ld_tag[31:10]; m_asid[ld_idx] = ld_tag[7:0];
        m_ppn[ld_idx] = ld_data[31:10]; m_v[ld_idx] = ld_data[9];
        m_sh[ld_idx] = ld_data[8]; m_sz[ld_idx] = ld_data[7:6];
        m_pr[ld_idx] = ld_data[5:4]; m_d[ld_idx] = ld_data[3];
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("res_valid", 32'(res_valid), 32'(e_valid));
      chk("res_hit", 32'(res_hit), 32'(e_hit));
      chk("res_miss", 32'(res_miss), 32'(e_miss));
      chk("res_multi", 32'(res_multi), 32'(e_multi));
      chk("urc", 32'(urc), 32'(m_urc));
      if (e_valid) begin
        chk("res_pa", res_pa, e_pa);
        chk("res_idx", 32'(res_idx), 32'(e_idx));
        chk("res_prot", 32'(res_prot), 32'(e_prot));
        chk("res_dirty", 32'(res_dirty), 32'(e_dirty));
      end
    end
  end

  function automatic logic [31:0] tg(input logic [21:0] vpn, input logic [7:0] id);
    return {vpn, 2'b11, id};
  endfunction
  function automatic logic [31:0] dt(input logic [21:0] ppn, input bit v, input bit sh,
                                     input logic [1:0] sz, input logic [1:0] pr, input bit d);
    return {ppn, v, sh, sz, pr, d, 3'b101};
  endfunction

  task automatic load(input int idx, input logic [31:0] t, input logic [31:0] d);
    @(negedge clk); ld_en = 1; ld_idx = 6'(idx); ld_tag = t; ld_data = d;
    @(negedge clk); ld_en = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] id, input bit pv, input bit sv, input bit it);
    @(negedge clk); lk_req = 1; lk_va = va; lk_asid = id; lk_priv = pv; lk_sv = sv; lk_internal = it;
    @(negedge clk); lk_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired in phase %s actual=hung expected=finished", phase);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    urb = 6'd0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    repeat (2) @(negedge clk);

    phase = "R1 R5 basic load and hit";
    load(5, tg(22'h00123, 8'h11), dt(22'h2A5A5, 1, 0, 2'd0, 2'd3, 1));
    look({22'h00123, 10'h2C4}, 8'h11, 0, 0, 0);
    look({22'h00124, 10'h2C4}, 8'h11, 0, 0, 0);

    phase = "R2 page sizes";
    load(10, tg(22'h10007, 8'h11), dt(22'h3FFFF, 1, 0, 2'd1, 2'd1, 0));
    load(20, tg(22'h20040, 8'h11), dt(22'h155AB, 1, 0, 2'd2, 2'd2, 1));
    load(30, tg(22'h30C00, 8'h11), dt(22'h0ABCD, 1, 0, 2'd3, 2'd0, 0));
    look(32'h0400_1ABC, 8'h11, 0, 0, 0);
    look(32'h0400_1FFF, 8'h11, 0, 0, 0);
    look(32'h0400_2000, 8'h11, 0, 0, 0);
    look(32'h0801_FFFC, 8'h11, 0, 0, 0);
    look(32'h0802_0000, 8'h11, 0, 0, 0);
    look(32'h0C3F_FFF0, 8'h11, 0, 0, 0);
    look(32'h0C40_0000, 8'h11, 0, 0, 0);

    phase = "R3 invalid entry";
    load(40, tg(22'h0A000, 8'h11), dt(22'h01234, 0, 1, 2'd3, 2'd3, 1));
    look({22'h0A000, 10'h004}, 8'h11, 0, 0, 0);

    phase = "R4 identifier rule";
    load(41, tg(22'h0B000, 8'h22), dt(22'h00777, 1, 0, 2'd0, 2'd1, 1));
    load(42, tg(22'h0C000, 8'h22), dt(22'h00888, 1, 1, 2'd0, 2'd2, 0));
    look({22'h0B000, 10'h010}, 8'h33, 0, 0, 0);
    look({22'h0B000, 10'h010}, 8'h33, 1, 0, 0);
    look({22'h0B000, 10'h010}, 8'h33, 0, 1, 0);
    look({22'h0B000, 10'h010}, 8'h33, 1, 1, 0);
    look({22'h0B000, 10'h010}, 8'h22, 0, 0, 0);
    look({22'h0C000, 10'h3F0}, 8'h44, 0, 0, 0);

    phase = "R6 R11 miss and multi-hit";
    load(50, tg(22'h3C000, 8'h11), dt(22'h11111, 1, 1, 2'd3, 2'd3, 1));
    load(51, tg(22'h3C001, 8'h11), dt(22'h22222, 1, 1, 2'd0, 2'd1, 1));
    look(32'h0F00_0400, 8'h11, 0, 0, 0);
    look(32'h0F00_0000, 8'h11, 0, 0, 0);
    look(32'h7000_0000, 8'h11, 0, 0, 0);

    phase = "R7 replacement pointer";
    urb = 6'd7;
    for (int k = 0; k < 12; k++) look(32'h0F00_0000, 8'h11, 0, 0, (k % 4) == 3);
    urb = 6'd0;

    phase = "R9 load and lookup together";
    @(negedge clk);
    ld_en = 1; ld_idx = 6'd5; ld_tag = tg(22'h00123, 8'h11); ld_data = dt(22'h3000F, 1, 0, 2'd0, 2'd2, 0);
    lk_req = 1; lk_va = {22'h00123, 10'h001}; lk_asid = 8'h11; lk_priv = 0; lk_sv = 0; lk_internal = 0;
    @(negedge clk); ld_en = 0; lk_req = 0;
    look({22'h00123, 10'h001}, 8'h11, 0, 0, 0);

    phase = "R8 flush";
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    look({22'h00123, 10'h001}, 8'h11, 0, 0, 0);
    look(32'h0F00_0000, 8'h11, 0, 0, 0);
    load(9, tg(22'h00500, 8'h01), dt(22'h00600, 1, 0, 2'd0, 2'd1, 0));
    @(negedge clk); flush = 1; ld_en = 1; ld_idx = 6'd7;
    ld_tag = tg(22'h00200, 8'h01); ld_data = dt(22'h00300, 1, 0, 2'd1, 2'd3, 1);
    @(negedge clk); flush = 0; ld_en = 0;
    look({22'h00200, 10'h155}, 8'h01, 0, 0, 0);
    look({22'h00500, 10'h155}, 8'h01, 0, 0, 0);

    phase = "R1 R2 R4 R6 R7 random mix";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (k % 300 == 0) urb = 6'($urandom);
      flush = ($urandom % 97) == 0;
      ld_en = ($urandom % 4) == 0;
      ld_idx = 6'($urandom);
      ld_tag = {10'h0, 8'($urandom % 16), 4'($urandom), 2'b00, 8'($urandom % 4)};
      ld_data = $urandom;
      lk_req = ($urandom % 2) == 0;
      lk_va = {10'h0, 8'($urandom % 16), 14'($urandom)};
      lk_asid = 8'($urandom % 4);
      lk_priv = $urandom; lk_sv = $urandom; lk_internal = ($urandom % 5) == 0;
    end
    @(negedge clk); flush = 0; ld_en = 0; lk_req = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule